// File: doc/BRIEF.md
# Clause-22 Management Frame Controller

This block drives a two-wire station management bus: a management clock (`mdc`) and a bidirectional data line split into `mdio_o`, `mdio_oe` and `mdio_i`. Software supplies a complete, pre-encoded 32-bit frame as one command word. The controller can prefix the frame with a run of ones. It then shifts the frame out most significant bit first. On a read it gives up the line after the register-address field and collects the 16 data bits that the managed device returns.

The captured read data replaces the low half of the same register that held the command. When the frame ends, the controller sets an interrupt status bit, and a mask input gates that bit onto the interrupt line. A configuration byte selects the management clock rate through a divider on the system clock, and one of its bits turns the preamble on or off.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset `mdc`, `mdio_oe`, `busy`, `irq_status` and `irq` are all 0 and `data_out` is 0.
- R2: A `cmd_wr` pulse while idle loads `cmd_wdata` into `data_out` and raises `busy` from the next clock edge. `busy` falls at the falling `mdc` edge that ends the last frame bit, and `mdc` is then low.
- R3: If bit 7 of the configuration byte is 1 when a frame starts, 32 ones precede the frame on `mdio_o`. If it is 0, the frame begins at once.
- R4: The command word goes out MSB first, bit 31 down to bit 0, unaltered, including the start, opcode, device address (27:23), register address (22:18) and turnaround fields. `mdio_o` changes only while `mdc` is low.
- R5: A word whose bits 29:28 are 2'b10 is a read. The controller drives bits 31..18 only and releases `mdio_oe` for the last 18 bit periods. It samples `mdio_i` on the rising `mdc` edge of each of the last 16 bit periods into `data_out[15:0]`, MSB first, and leaves `data_out[31:16]` unchanged.
- R6: Each `mdc` half-period lasts (D+1) system clocks, where D is bits 6:0 of the configuration byte and a D of 0 counts as 1. `mdc` stays low while idle.
- R7: A `cmd_wr` pulse while `busy` is 1 is ignored. It changes neither the frame on the bus nor `data_out`.
- R8: Frame completion sets `irq_status`. `irq_clr` clears it, with a set in the same cycle taking priority. `irq` equals `irq_status` AND `irq_mask`.
- R9: `mdio_oe` is 0 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_wr | input | 1 | Load the configuration byte |
| freq_wdata | input | DIV_W+1 | Bit DIV_W: preamble enable; lower bits: divider |
| cmd_wr | input | 1 | Write command word (starts a frame when idle) |
| cmd_wdata | input | 32 | Pre-encoded frame word |
| irq_mask | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clear the completion status |
| mdio_i | input | 1 | Data line as seen on the bus |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| busy | output | 1 | Frame in progress |
| data_out | output | 32 | Command/read-data register |
| irq_status | output | 1 | Completion status |
| irq | output | 1 | Masked interrupt |

## Verification
Most internal state errors show up on the bus within one `mdc` period. A bad bit counter shows as the wrong number of driven bits, or the wrong number of released bits, before `busy` falls. A wrong divider count shows in the interval between `mdc` toggles. A wrong capture index appears in `data_out[15:0]` when the read frame ends. A serial model of the managed device records every driven bit on the rising edges of `mdc` and feeds back read data on the released periods. A scoreboard then compares the bit count, bit values, release length, toggle spacing, final register contents and completion status for each frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_BITS = 32;
    localparam int RD_BITS    = 16;
    localparam int FIDX_W     = $clog2(FRAME_BITS);
    // last frame bit still driven on a read (register-address LSB)
    localparam int LAST_DRIVEN_RD = 18;
    localparam int OPC_HI = 29;
    localparam int OPC_LO = 28;
    localparam logic [1:0] OPC_READ = 2'b10;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PRE   = 2'd1,
        PH_FRAME = 2'd2
    } phase_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [DIV_W-1:0] last_cnt;
    logic             tick;

    always_comb begin
        st_d     = st_q;
        // half period = effective divider + 1 clocks; divider 0 acts as 1
        last_cnt = (div == '0) ? DIV_W'(1) : div;
        tick     = run && (st_q.cnt == last_cnt);
        rise     = tick && !st_q.mdc;
        fall     = tick && st_q.mdc;
        if (!run) begin
            st_d = '0;
        end else if (tick) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc = st_q.mdc;
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_wr,
    input  logic [FRAME_BITS-1:0] cmd_wdata,
    input  logic                  pre_en,
    input  logic                  rise,
    input  logic                  fall,
    input  logic                  mdio_i,
    output logic                  busy,
    output logic                  done,
    output logic [FRAME_BITS-1:0] data,
    output logic                  mdio_o,
    output logic                  mdio_oe
);
    localparam int PRE_W = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 1;
    localparam int POS_W = (PRE_W > FIDX_W) ? PRE_W : FIDX_W;

    typedef struct packed {
        phase_t                phase;
        logic [POS_W-1:0]      pos;
        logic                  is_rd;
        logic [FRAME_BITS-1:0] word;
    } eng_state_t;

    eng_state_t st_d, st_q;
    logic [FIDX_W-1:0] bit_idx;
    logic              released;

    assign bit_idx  = st_q.pos[FIDX_W-1:0];
    assign released = st_q.is_rd && (int'(st_q.pos) < LAST_DRIVEN_RD);

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (cmd_wr) begin
                    st_d.word  = cmd_wdata;
                    st_d.is_rd = (cmd_wdata[OPC_HI:OPC_LO] == OPC_READ);
                    if (pre_en) begin
                        st_d.phase = PH_PRE;
                        st_d.pos   = POS_W'(PRE_LEN - 1);
                    end else begin
                        st_d.phase = PH_FRAME;
                        st_d.pos   = POS_W'(FRAME_BITS - 1);
                    end
                end
            end
            PH_PRE: begin
                if (fall) begin
                    if (st_q.pos == '0) begin
                        st_d.phase = PH_FRAME;
                        st_d.pos   = POS_W'(FRAME_BITS - 1);
                    end else begin
                        st_d.pos = st_q.pos - POS_W'(1);
                    end
                end
            end
            PH_FRAME: begin
                if (rise && st_q.is_rd && (int'(st_q.pos) < RD_BITS)) begin
                    st_d.word[bit_idx] = mdio_i;
                end
                if (fall) begin
                    if (st_q.pos == '0) begin
                        st_d.phase = PH_IDLE;
                        done       = 1'b1;
                    end else begin
                        st_d.pos = st_q.pos - POS_W'(1);
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, default: '0};
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q.phase)
            PH_PRE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            PH_FRAME: begin
                mdio_o  = released ? 1'b0 : st_q.word[bit_idx];
                mdio_oe = !released;
            end
            default: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
        endcase
    end

    assign busy = (st_q.phase != PH_IDLE);
    assign data = st_q.word;
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 7,
    parameter int PRE_LEN = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  freq_wr,
    input  logic [DIV_W:0]        freq_wdata,
    input  logic                  cmd_wr,
    input  logic [FRAME_BITS-1:0] cmd_wdata,
    input  logic                  irq_mask,
    input  logic                  irq_clr,
    input  logic                  mdio_i,
    output logic                  mdc,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  busy,
    output logic [FRAME_BITS-1:0] data_out,
    output logic                  irq_status,
    output logic                  irq
);
    typedef struct packed {
        logic [DIV_W:0] cfg;
        logic           stat;
    } top_state_t;

    top_state_t st_d, st_q;
    logic rise, fall, done;

    always_comb begin
        st_d = st_q;
        if (freq_wr)      st_d.cfg  = freq_wdata;
        if (irq_clr)      st_d.stat = 1'b0;
        if (done)         st_d.stat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .div  (st_q.cfg[DIV_W-1:0]),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_engine #(.PRE_LEN(PRE_LEN)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_wdata(cmd_wdata),
        .pre_en   (st_q.cfg[DIV_W]),
        .rise     (rise),
        .fall     (fall),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .done     (done),
        .data     (data_out),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    assign irq_status = st_q.stat;
    assign irq        = st_q.stat & irq_mask;
endmodule

// File: rtl/mdio_ctrl_chk.sv
module mdio_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic        irq_mask,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy,
    input logic [31:0] data_out,
    input logic        irq_status,
    input logic        irq
);
    // R9: line released while idle
    a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    // R6: clock parked low when idle
    a_r6_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R4: driven data only changes while mdc is low
    a_r4_change_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> !mdc);

    // R7: command write during a frame leaves the upper register half alone
    a_r7_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> $stable(data_out[31:16]));

    // R8: status rises only at frame end
    a_r8_status_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status) |-> $fell(busy));

    // R8: masked interrupt
    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_mask && irq_status));
endmodule

bind mdio_ctrl mdio_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .irq_mask  (irq_mask),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .busy      (busy),
    .data_out  (data_out),
    .irq_status(irq_status),
    .irq       (irq)
);

// File: tb/test_mdio_ctrl.sv
module test_mdio_ctrl;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [63:0] bits;
        int          nbits;
        int          nrel;
        logic [31:0] data;
        int          half;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        freq_wr = 1'b0;
    logic [7:0]  freq_wdata = '0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        irq_mask = 1'b0;
    logic        irq_clr = 1'b0;
    logic        mdio_i = 1'b1;
    logic        mdc, mdio_o, mdio_oe, busy, irq_status, irq;
    logic [31:0] data_out;

    int checks = 0;
    int fails  = 0;
    exp_t exp_q[$];
    logic [15:0] phy_word = '0;

    // monitor state
    logic        prev_mdc = 1'b0;
    logic        prev_busy = 1'b0;
    logic [63:0] cap_bits;
    int          cap_n, rel_n, iv, iv_min, iv_max;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_ctrl i_mdio_ctrl (
        .clk(clk), .rst_n(rst_n), .freq_wr(freq_wr), .freq_wdata(freq_wdata),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .irq_mask(irq_mask),
        .irq_clr(irq_clr), .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .busy(busy), .data_out(data_out),
        .irq_status(irq_status), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // managed-device model and scoreboard monitor
    always @(negedge clk) begin
        if (busy && !prev_busy) begin
            cap_bits = '0; cap_n = 0; rel_n = 0; iv = 0;
            iv_min = 1 << 30; iv_max = 0;
        end else if (prev_busy) begin
            iv++;
            if (mdc != prev_mdc) begin
                if (iv < iv_min) iv_min = iv;
                if (iv > iv_max) iv_max = iv;
                iv = 0;
                if (mdc) begin
                    if (mdio_oe) begin
                        cap_bits = {cap_bits[62:0], mdio_o};
                        cap_n++;
                    end else begin
                        rel_n++;
                    end
                end
            end
            if (!busy) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected frame", 0, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(cap_n == e.nbits, "R3 driven bit count", 64'(cap_n), 64'(e.nbits));
                    chk(cap_bits == e.bits, "R4 serial bits", cap_bits, e.bits);
                    chk(rel_n == e.nrel, "R5 released periods", 64'(rel_n), 64'(e.nrel));
                    chk(data_out == e.data, "R5 R7 data register", 64'(data_out), 64'(e.data));
                    chk(iv_min == e.half && iv_max == e.half, "R6 half period",
                        64'(iv_max), 64'(e.half));
                    chk(irq_status == 1'b1, "R8 status set", 64'(irq_status), 1);
                    chk(mdc == 1'b0, "R2 mdc low at end", 64'(mdc), 0);
                end
            end
        end
        prev_mdc  = mdc;
        prev_busy = busy;
        mdio_i = (rel_n >= 2 && rel_n < 18) ? phy_word[17 - rel_n] : 1'b1;
    end

    task automatic set_cfg(input bit pre, input int div);
        @(negedge clk);
        freq_wdata = {pre, 7'(div)};
        freq_wr = 1'b1;
        @(negedge clk);
        freq_wr = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic send(input logic [31:0] word, input bit pre, input int div,
                        input logic [15:0] phy, input bit poke);
        exp_t e;
        bit rd;
        set_cfg(pre, div);
        clear_irq();
        phy_word = phy;
        rd = (word[29:28] == 2'b10);
        e.half = ((div == 0) ? 1 : div) + 1;
        if (rd) begin
            e.nbits = (pre ? 32 : 0) + 14;
            e.bits  = pre ? {18'h0, 32'hFFFF_FFFF, word[31:18]} : {50'h0, word[31:18]};
            e.nrel  = 18;
            e.data  = {word[31:16], phy};
        end else begin
            e.nbits = (pre ? 32 : 0) + 32;
            e.bits  = pre ? {32'hFFFF_FFFF, word} : {32'h0, word};
            e.nrel  = 0;
            e.data  = word;
        end
        exp_q.push_back(e);
        @(negedge clk);
        cmd_wdata = word;
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(busy == 1'b1, "R2 busy after write", 64'(busy), 1);
        chk(data_out == word, "R2 word loaded", 64'(data_out), 64'(word));
        if (poke) begin
            repeat (20) @(negedge clk);
            cmd_wdata = ~word;
            cmd_wr = 1'b1;
            @(negedge clk);
            cmd_wr = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(mdio_oe == 1'b0, "R9 released when idle", 64'(mdio_oe), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mdc == 0 && mdio_oe == 0 && busy == 0 && irq_status == 0 && irq == 0,
            "R1 reset outputs", {mdc, mdio_oe, busy, irq_status, irq}, 0);
        chk(data_out == 0, "R1 reset data", 64'(data_out), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3/R4: write with preamble, device 5 register 3
        send(32'h528E_A5C3, 1'b1, 3, 16'h0, 1'b0);
        // R4: write without preamble, R6 divider 0 acts as 1
        send(32'h5FFE_0001, 1'b0, 0, 16'h0, 1'b0);
        // R6: divider 1
        send(32'h5002_8000, 1'b0, 1, 16'h0, 1'b0);
        // R5: read without preamble
        send(32'h608A_0000, 1'b0, 2, 16'h1234, 1'b0);
        // R5: read with preamble, other pattern
        send(32'h6FFE_FFFF, 1'b1, 5, 16'hC35A, 1'b0);
        // R7: write attempted mid-frame
        send(32'h5102_00F0, 1'b0, 2, 16'h0, 1'b1);

        // R8: masking and clear
        chk(irq_status == 1 && irq == 0, "R8 masked irq", {irq_status, irq}, 2'b10);
        irq_mask = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R8 unmasked irq", 64'(irq), 1);
        clear_irq();
        chk(irq_status == 0 && irq == 0, "R8 cleared", {irq_status, irq}, 0);
        chk(exp_q.size() == 0, "R2 all frames seen", 64'(exp_q.size()), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule